// File: doc/BRIEF.md
# Mixed Level/Message Interrupt Source Bank

This block holds a bank of interrupt sources. Each source is either level-sensitive or message-signalled, and a static strap input selects which. Each source keeps its own routing entry, made of a target server, a priority and a saved priority. It also keeps a small set of status flags. The block turns line changes and message events into offers. An offer is a tuple of server, global source number and priority, sent toward the presentation controllers.

The presentation side answers with three kinds of notification. A reject means an offer could not be taken. An end-of-interrupt means a level source has been serviced. A resend asks every source to try again. The block applies each one with rules that depend on the source type.

A configuration port writes one routing entry at a time. Pending offers are held as one request flag per source. A single valid/ready channel drains them, one offer per accepted cycle, lowest local index first.

Top module: `irq_source_bank`

## Requirements
- R1: After reset, every priority and saved priority reads as 0xFF and every status flag and pending request is clear, so no offer is valid. The type strap `src_is_level` is an input and is unaffected by reset.
- R2: An offer's number equals the parameter BASE plus the local index of the source. Its server and priority come from that source's routing entry.
- R3: For a message source (`src_is_level` bit = 0), a one-cycle event on a masked source (priority 0xFF) sets its masked-pending flag and makes no offer. On an unmasked source, the event makes an offer that is valid in the cycle after the event.
- R4: A routing write that gives a masked-pending message source a priority other than 0xFF clears the flag and makes one offer. A repeated write of the same entry makes no further offer.
- R5: For a level source (`src_is_level` bit = 1), an offer is made only when the source is unmasked, its line is high and its sent flag is clear. Making the offer sets sent, and while sent is set, neither a resend nor a write offers the source again.
- R6: A level source's asserted flag follows its line. A source whose line has dropped is not offered on resend, even after its sent flag is cleared.
- R7: A reject sets the rejected flag of a message source and clears the sent flag of a level source. On the next resend, a rejected unmasked message source is offered once, and a level source whose line is still high is offered.
- R8: An end-of-interrupt clears the sent flag of a level source. It does not itself make an offer, and it has no effect on a message source.
- R9: A resend clears the rejected flag of a masked message source without offering it. A later unmasking write then makes no offer.
- R10: While any request is pending, `offer_valid` is high and shows the lowest-indexed pending source. That request is removed only in a cycle where `offer_ready` is high, so at most one offer is taken per cycle.
- R11: Reject and end-of-interrupt numbers below BASE or at or above BASE+NUM_SRC change no state.
- R12: A routing write that sets priority 0xFF withdraws any pending request of that source. No offer ever carries priority 0xFF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| src_is_level | input | NUM_SRC | Per-source type strap, 1 = level, 0 = message |
| lvl_lines | input | NUM_SRC | Level input lines (used by level sources) |
| msg_events | input | NUM_SRC | One-cycle message event pulses (used by message sources) |
| cfg_we | input | 1 | Routing entry write strobe |
| cfg_idx | input | IDX_W | Local index of the entry written |
| cfg_server | input | SRV_W | Target server to store |
| cfg_prio | input | 8 | Priority to store, 0xFF masks |
| cfg_saved_prio | input | 8 | Saved priority to store |
| rej_valid | input | 1 | Reject notification strobe |
| rej_num | input | GNUM_W | Global number being rejected |
| eoi_valid | input | 1 | End-of-interrupt strobe |
| eoi_num | input | GNUM_W | Global number being completed |
| resend_req | input | 1 | Resend request to all sources |
| offer_valid | output | 1 | An offer is presented |
| offer_ready | input | 1 | Downstream takes the offer this cycle |
| offer_server | output | SRV_W | Target server of the offer |
| offer_num | output | GNUM_W | Global source number of the offer |
| offer_prio | output | 8 | Priority of the offer |

## Verification
The bench builds the bank with NUM_SRC=6, BASE=32, GNUM_W=10 and SRV_W=3, with the level and message types alternating across the indices. Because six is not a power of two, the local index field can take values with no source behind them. Numbers just below BASE and just past the last source can therefore be sent as rejects and completions. Six sources are also enough to keep several requests of both types pending at once behind a stalled channel, which exercises the lowest-index ordering.

// File: rtl/irqsb_pkg.sv
`timescale 1ns/1ps
package irqsb_pkg;

    localparam int PRIO_W = 8;
    localparam logic [PRIO_W-1:0] PRIO_OFF = '1;

    typedef logic [PRIO_W-1:0] prio_t;

    typedef enum logic {
        KIND_MSG = 1'b0,
        KIND_LVL = 1'b1
    } src_kind_e;

    // Per-source status flags; level sources use asrt/sent, message sources rej/mpend
    typedef struct packed {
        logic asrt;
        logic sent;
        logic rej;
        logic mpend;
    } src_stat_t;

    function automatic logic prio_masked(prio_t p);
        return p == PRIO_OFF;
    endfunction

endpackage

// File: rtl/irqsb_num_dec.sv
`timescale 1ns/1ps
module irqsb_num_dec #(
    parameter int unsigned NUM_SRC = 16,
    parameter int unsigned GNUM_W  = 12,
    parameter int unsigned BASE    = 256
) (
    input  logic              valid,
    input  logic [GNUM_W-1:0] num,
    output logic [NUM_SRC-1:0] hit
);
    localparam logic [GNUM_W-1:0] BASE_V = GNUM_W'(BASE);

    logic [GNUM_W-1:0] off;
    logic              above;

    assign off   = num - BASE_V;
    assign above = (num >= BASE_V);

    for (genvar i = 0; i < NUM_SRC; i++) begin : g_hit
        assign hit[i] = valid && above && (off == GNUM_W'(i));
    end
endmodule

// File: rtl/irqsb_pick_low.sv
`timescale 1ns/1ps
module irqsb_pick_low #(
    parameter int unsigned NUM_SRC = 16,
    parameter int unsigned IDX_W   = 4
) (
    input  logic [NUM_SRC-1:0] req,
    input  logic               ready,
    output logic               valid,
    output logic [IDX_W-1:0]   idx,
    output logic [NUM_SRC-1:0] grant
);
    logic [NUM_SRC-1:0] lowest;

    assign lowest = req & (~req + NUM_SRC'(1));
    assign valid  = |req;
    assign grant  = ready ? lowest : '0;

    always_comb begin
        idx = '0;
        for (int i = NUM_SRC - 1; i >= 0; i--) begin
            if (req[i]) idx = IDX_W'(i);
        end
    end
endmodule

// File: rtl/irqsb_slot.sv
`timescale 1ns/1ps
module irqsb_slot
    import irqsb_pkg::*;
#(
    parameter int unsigned SRV_W = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             is_lvl,
    input  logic             lvl_line,
    input  logic             msg_evt,
    input  logic             wr_hit,
    input  logic [SRV_W-1:0] wr_srv,
    input  prio_t            wr_prio,
    input  prio_t            wr_saved,
    input  logic             rej_hit,
    input  logic             eoi_hit,
    input  logic             resend,
    input  logic             grant,
    output logic             req,
    output logic [SRV_W-1:0] srv,
    output prio_t            prio,
    output prio_t            saved,
    output logic             asrt_o,
    output logic             sent_o
);
    logic [SRV_W-1:0] srv_q, srv_d;
    prio_t            prio_q, prio_d, saved_q, saved_d;
    src_stat_t        st_q, st_d;
    logic             req_q, req_d;
    logic             fire, lvl_eval, now_masked;
    src_kind_e        kind;

    assign kind = src_kind_e'(is_lvl);

    always_comb begin
        srv_d    = srv_q;
        prio_d   = prio_q;
        saved_d  = saved_q;
        st_d     = st_q;
        fire     = 1'b0;
        lvl_eval = 1'b0;
        if (wr_hit) begin
            srv_d   = wr_srv;
            prio_d  = wr_prio;
            saved_d = wr_saved;
        end
        now_masked = prio_masked(prio_d);
        if (kind == KIND_LVL) begin
            lvl_eval  = (lvl_line != st_q.asrt) || wr_hit || resend;
            st_d.asrt = lvl_line;
            if (rej_hit || eoi_hit) st_d.sent = 1'b0;
            if (lvl_eval && !now_masked && st_d.asrt && !st_d.sent) begin
                st_d.sent = 1'b1;
                fire      = 1'b1;
            end
        end else begin
            if (rej_hit) st_d.rej = 1'b1;
            if (msg_evt) begin
                if (now_masked) st_d.mpend = 1'b1;
                else            fire       = 1'b1;
            end
            if (resend && st_q.rej) begin
                st_d.rej = 1'b0;
                if (!now_masked) fire = 1'b1;
            end
            if (wr_hit && st_q.mpend && !now_masked) begin
                st_d.mpend = 1'b0;
                fire       = 1'b1;
            end
        end
        req_d = (req_q && !grant) || fire;
        if (wr_hit && now_masked) req_d = 1'b0;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            srv_q   <= '0;
            prio_q  <= PRIO_OFF;
            saved_q <= PRIO_OFF;
            st_q    <= '0;
            req_q   <= 1'b0;
        end else begin
            srv_q   <= srv_d;
            prio_q  <= prio_d;
            saved_q <= saved_d;
            st_q    <= st_d;
            req_q   <= req_d;
        end
    end

    assign req    = req_q;
    assign srv    = srv_q;
    assign prio   = prio_q;
    assign saved  = saved_q;
    assign asrt_o = st_q.asrt;
    assign sent_o = st_q.sent;
endmodule

// File: rtl/irq_source_bank.sv
`timescale 1ns/1ps
module irq_source_bank
    import irqsb_pkg::*;
#(
    parameter int unsigned NUM_SRC = 16,
    parameter int unsigned SRV_W   = 4,
    parameter int unsigned GNUM_W  = 12,
    parameter int unsigned BASE    = 256,
    localparam int unsigned IDX_W  = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [NUM_SRC-1:0] src_is_level,
    input  logic [NUM_SRC-1:0] lvl_lines,
    input  logic [NUM_SRC-1:0] msg_events,
    input  logic               cfg_we,
    input  logic [IDX_W-1:0]   cfg_idx,
    input  logic [SRV_W-1:0]   cfg_server,
    input  logic [7:0]         cfg_prio,
    input  logic [7:0]         cfg_saved_prio,
    input  logic               rej_valid,
    input  logic [GNUM_W-1:0]  rej_num,
    input  logic               eoi_valid,
    input  logic [GNUM_W-1:0]  eoi_num,
    input  logic               resend_req,
    output logic               offer_valid,
    input  logic               offer_ready,
    output logic [SRV_W-1:0]   offer_server,
    output logic [GNUM_W-1:0]  offer_num,
    output logic [7:0]         offer_prio
);
    logic [NUM_SRC-1:0]        wr_hit, rej_hit, eoi_hit;
    logic [NUM_SRC-1:0]        req_vec, grant_vec, sent_vec, asrt_vec;
    logic [SRV_W-1:0]          srv_arr  [NUM_SRC];
    prio_t                     prio_arr [NUM_SRC];
    logic [NUM_SRC*PRIO_W-1:0] saved_flat;
    logic [IDX_W-1:0]          pick_idx;

    irqsb_num_dec #(.NUM_SRC(NUM_SRC), .GNUM_W(GNUM_W), .BASE(BASE)) u_rej_dec (
        .valid (rej_valid),
        .num   (rej_num),
        .hit   (rej_hit)
    );

    irqsb_num_dec #(.NUM_SRC(NUM_SRC), .GNUM_W(GNUM_W), .BASE(BASE)) u_eoi_dec (
        .valid (eoi_valid),
        .num   (eoi_num),
        .hit   (eoi_hit)
    );

    for (genvar i = 0; i < NUM_SRC; i++) begin : g_src
        assign wr_hit[i] = cfg_we && (cfg_idx == IDX_W'(i));

        irqsb_slot #(.SRV_W(SRV_W)) u_slot (
            .clk      (clk),
            .rst      (rst),
            .is_lvl   (src_is_level[i]),
            .lvl_line (lvl_lines[i]),
            .msg_evt  (msg_events[i]),
            .wr_hit   (wr_hit[i]),
            .wr_srv   (cfg_server),
            .wr_prio  (cfg_prio),
            .wr_saved (cfg_saved_prio),
            .rej_hit  (rej_hit[i]),
            .eoi_hit  (eoi_hit[i]),
            .resend   (resend_req),
            .grant    (grant_vec[i]),
            .req      (req_vec[i]),
            .srv      (srv_arr[i]),
            .prio     (prio_arr[i]),
            .saved    (saved_flat[i*PRIO_W +: PRIO_W]),
            .asrt_o   (asrt_vec[i]),
            .sent_o   (sent_vec[i])
        );
    end

    irqsb_pick_low #(.NUM_SRC(NUM_SRC), .IDX_W(IDX_W)) u_pick (
        .req   (req_vec),
        .ready (offer_ready),
        .valid (offer_valid),
        .idx   (pick_idx),
        .grant (grant_vec)
    );

    assign offer_server = srv_arr[pick_idx];
    assign offer_prio   = prio_arr[pick_idx];
    assign offer_num    = GNUM_W'(BASE) + GNUM_W'(pick_idx);
endmodule

// File: rtl/irq_source_bank_chk.sv
`timescale 1ns/1ps
module irq_source_bank_chk #(
    parameter int unsigned NUM_SRC = 16
) (
    input logic                 clk,
    input logic                 rst,
    input logic                 offer_valid,
    input logic                 offer_ready,
    input logic [7:0]           offer_prio,
    input logic                 cfg_we,
    input logic [NUM_SRC-1:0]   grant_vec,
    input logic [NUM_SRC-1:0]   sent_vec,
    input logic [NUM_SRC-1:0]   asrt_vec,
    input logic [NUM_SRC*8-1:0] saved_flat
);
    p_reset_quiet_r1: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (!offer_valid && saved_flat == '1));

    p_grant_onehot_r10: assert property (@(posedge clk) disable iff (rst)
        $onehot0(grant_vec));

    p_grant_needs_ready_r10: assert property (@(posedge clk) disable iff (rst)
        (|grant_vec) |-> (offer_ready && offer_valid));

    p_hold_stall_r10: assert property (@(posedge clk) disable iff (rst)
        (offer_valid && !offer_ready && !cfg_we) |=> offer_valid);

    p_no_masked_offer_r12: assert property (@(posedge clk) disable iff (rst)
        offer_valid |-> (offer_prio != 8'hFF));

    for (genvar i = 0; i < NUM_SRC; i++) begin : g_lvl
        p_sent_needs_line_r5: assert property (@(posedge clk) disable iff (rst)
            $rose(sent_vec[i]) |-> asrt_vec[i]);
    end
endmodule

bind irq_source_bank irq_source_bank_chk #(.NUM_SRC(NUM_SRC)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .offer_valid (offer_valid),
    .offer_ready (offer_ready),
    .offer_prio  (offer_prio),
    .cfg_we      (cfg_we),
    .grant_vec   (grant_vec),
    .sent_vec    (sent_vec),
    .asrt_vec    (asrt_vec),
    .saved_flat  (saved_flat)
);

// File: tb/irq_source_bank_bench.sv
`timescale 1ns/1ps
module irq_source_bank_bench;
    localparam int N      = 6;
    localparam int SRV_W  = 3;
    localparam int GNUM_W = 10;
    localparam int BASE   = 32;
    localparam int IDX_W  = 3;
    localparam logic [N-1:0] LVL_MAP = 6'b101010;
    localparam int OP_IDLE = 0, OP_MSG = 1, OP_LVL = 2, OP_WR = 3,
                   OP_REJ = 4, OP_EOI = 5, OP_RES = 6;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #4 clk = ~clk;

    logic [N-1:0]      lv = '0;
    logic [N-1:0]      msg_events = '0;
    logic              cfg_we = 1'b0;
    logic [IDX_W-1:0]  cfg_idx = '0;
    logic [SRV_W-1:0]  cfg_server = '0;
    logic [7:0]        cfg_prio = '0;
    logic [7:0]        cfg_saved_prio = '0;
    logic              rej_valid = 1'b0;
    logic [GNUM_W-1:0] rej_num = '0;
    logic              eoi_valid = 1'b0;
    logic [GNUM_W-1:0] eoi_num = '0;
    logic              resend_req = 1'b0;
    logic              offer_ready = 1'b0;
    logic              offer_valid;
    logic [SRV_W-1:0]  offer_server;
    logic [GNUM_W-1:0] offer_num;
    logic [7:0]        offer_prio;

    irq_source_bank #(.NUM_SRC(N), .SRV_W(SRV_W), .GNUM_W(GNUM_W), .BASE(BASE)) u_irq_source_bank (
        .clk(clk), .rst(rst), .src_is_level(LVL_MAP), .lvl_lines(lv),
        .msg_events(msg_events), .cfg_we(cfg_we), .cfg_idx(cfg_idx),
        .cfg_server(cfg_server), .cfg_prio(cfg_prio), .cfg_saved_prio(cfg_saved_prio),
        .rej_valid(rej_valid), .rej_num(rej_num), .eoi_valid(eoi_valid),
        .eoi_num(eoi_num), .resend_req(resend_req), .offer_valid(offer_valid),
        .offer_ready(offer_ready), .offer_server(offer_server),
        .offer_num(offer_num), .offer_prio(offer_prio)
    );

    int    n_chk = 0;
    int    n_bad = 0;
    string cur_tag = "R1";

    int m_prio [N];
    int m_srv  [N];
    bit m_as   [N];
    bit m_sent [N];
    bit m_rej  [N];
    bit m_mp   [N];
    bit m_req  [N];

    task automatic check(bit ok, string tag, string what, longint act, longint exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
        end
    endtask

    function automatic int lowest();
        for (int i = 0; i < N; i++) if (m_req[i]) return i;
        return -1;
    endfunction

    function automatic void model_reset();
        for (int i = 0; i < N; i++) begin
            m_prio[i] = 255; m_srv[i] = 0;
            m_as[i] = 0; m_sent[i] = 0; m_rej[i] = 0; m_mp[i] = 0; m_req[i] = 0;
        end
    endfunction

    function automatic void model_update(int op, int a, int b, int c, bit rdy);
        int g = lowest();
        if (rdy && g >= 0) m_req[g] = 0;
        for (int i = 0; i < N; i++) begin
            bit fire = 0;
            bit hw   = (op == OP_WR)  && (a == i);
            bit rj   = (op == OP_REJ) && (a == BASE + i);
            bit eo   = (op == OP_EOI) && (a == BASE + i);
            bit rs   = (op == OP_RES);
            bit ms   = (op == OP_MSG) && (a == i);
            if (hw) begin m_srv[i] = b; m_prio[i] = c; end
            if (LVL_MAP[i]) begin
                bit ev = (lv[i] != m_as[i]) || hw || rs;
                m_as[i] = lv[i];
                if (rj || eo) m_sent[i] = 0;
                if (ev && m_prio[i] != 255 && m_as[i] && !m_sent[i]) begin
                    m_sent[i] = 1; fire = 1;
                end
            end else begin
                if (rj) m_rej[i] = 1;
                if (ms) begin
                    if (m_prio[i] == 255) m_mp[i] = 1; else fire = 1;
                end
                if (rs && m_rej[i]) begin
                    m_rej[i] = 0;
                    if (m_prio[i] != 255) fire = 1;
                end
                if (hw && m_mp[i] && c != 255) begin m_mp[i] = 0; fire = 1; end
            end
            if (fire) m_req[i] = 1;
            if (hw && c == 255) m_req[i] = 0;
        end
    endfunction

    task automatic compare();
        int j = lowest();
        check(offer_valid == (j >= 0), cur_tag, "offer_valid", longint'(offer_valid), longint'(j >= 0));
        if (j >= 0 && offer_valid) begin
            check(offer_num == GNUM_W'(BASE + j), cur_tag, "offer_num (R2)",
                  longint'(offer_num), longint'(BASE + j));
            check({offer_server, offer_prio} == {SRV_W'(m_srv[j]), 8'(m_prio[j])}, cur_tag,
                  "offer server/prio", longint'({offer_server, offer_prio}),
                  longint'({SRV_W'(m_srv[j]), 8'(m_prio[j])}));
        end
    endtask

    task automatic step(int op, int a = 0, int b = 0, int c = 0, bit rdy = 1'b1);
        compare();
        offer_ready = rdy;
        case (op)
            OP_MSG: msg_events[a] = 1'b1;
            OP_LVL: lv[a] = b[0];
            OP_WR: begin
                cfg_we = 1'b1; cfg_idx = IDX_W'(a); cfg_server = SRV_W'(b);
                cfg_prio = 8'(c); cfg_saved_prio = 8'(c) ^ 8'h3c;
            end
            OP_REJ: begin rej_valid = 1'b1; rej_num = GNUM_W'(a); end
            OP_EOI: begin eoi_valid = 1'b1; eoi_num = GNUM_W'(a); end
            OP_RES: resend_req = 1'b1;
            default: ;
        endcase
        @(posedge clk);
        model_update(op, a, b, c, rdy);
        @(negedge clk);
        msg_events = '0; cfg_we = 1'b0; rej_valid = 1'b0; eoi_valid = 1'b0; resend_req = 1'b0;
    endtask

    task automatic do_reset();
        rst = 1'b1; lv = '0; offer_ready = 1'b0;
        repeat (2) @(negedge clk);
        rst = 1'b0;
        model_reset();
    endtask

    initial begin
        #(8 * 150000);
        n_chk++; n_bad++;
        $display("FAIL R10 watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        model_reset();
        @(negedge clk);
        do_reset();

        cur_tag = "R1";
        step(OP_IDLE); step(OP_MSG, 0); step(OP_IDLE);

        cur_tag = "R3";
        step(OP_WR, 2, 5, 3); step(OP_MSG, 2, 0, 0, 0);
        cur_tag = "R2";
        step(OP_IDLE, 0, 0, 0, 0); step(OP_IDLE); step(OP_IDLE);

        cur_tag = "R4";
        step(OP_WR, 0, 1, 4); step(OP_IDLE); step(OP_WR, 0, 1, 4); step(OP_IDLE); step(OP_IDLE);

        cur_tag = "R5";
        step(OP_WR, 1, 2, 2); step(OP_LVL, 1, 1); step(OP_IDLE); step(OP_IDLE);
        step(OP_RES); step(OP_IDLE);

        cur_tag = "R8";
        step(OP_EOI, BASE + 1); step(OP_IDLE); step(OP_RES); step(OP_IDLE);
        step(OP_EOI, BASE + 2); step(OP_RES); step(OP_IDLE);

        cur_tag = "R7";
        step(OP_REJ, BASE + 2); step(OP_RES); step(OP_IDLE); step(OP_RES); step(OP_IDLE);
        step(OP_REJ, BASE + 1); step(OP_RES); step(OP_IDLE);

        cur_tag = "R6";
        step(OP_LVL, 1, 0); step(OP_EOI, BASE + 1); step(OP_RES); step(OP_IDLE);

        cur_tag = "R9";
        step(OP_WR, 4, 6, 6); step(OP_REJ, BASE + 4); step(OP_WR, 4, 6, 255);
        step(OP_RES); step(OP_WR, 4, 6, 6); step(OP_IDLE);

        cur_tag = "R11";
        step(OP_WR, 3, 1, 1); step(OP_LVL, 3, 1); step(OP_IDLE);
        step(OP_REJ, BASE + 6); step(OP_REJ, BASE - 1); step(OP_EOI, BASE + 6);
        step(OP_EOI, BASE + 7); step(OP_RES); step(OP_IDLE);

        cur_tag = "R12";
        step(OP_WR, 5, 7, 7); step(OP_LVL, 5, 1, 0, 0); step(OP_IDLE, 0, 0, 0, 0);
        step(OP_WR, 5, 7, 255, 0); step(OP_IDLE); step(OP_IDLE);

        cur_tag = "R10";
        step(OP_MSG, 4, 0, 0, 0); step(OP_MSG, 2, 0, 0, 0); step(OP_MSG, 0, 0, 0, 0);
        step(OP_IDLE, 0, 0, 0, 0);
        repeat (4) step(OP_IDLE);

        cur_tag = "R1";
        do_reset();
        step(OP_IDLE); step(OP_MSG, 2); step(OP_IDLE); step(OP_LVL, 1, 1); step(OP_IDLE);

        cur_tag = "R10";
        for (int k = 0; k < 2500; k++) begin
            int op = int'($urandom % 7);
            int a  = int'($urandom % N);
            int b  = int'($urandom % 8);
            int c  = (($urandom % 4) == 0) ? 255 : int'($urandom % 10);
            bit rd = (($urandom % 4) != 0);
            if (op == OP_REJ || op == OP_EOI) a = BASE - 1 + int'($urandom % (N + 2));
            if (op == OP_LVL) b = b % 2;
            step(op, a, b, c, rd);
        end
        compare();

        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule